// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast clock, taken from a VCO after its input stage, down to the rate of a PLL reference so the phase comparator can compare the two. It produces one single-cycle pulse on `div_pulse` at the end of each complete divide cycle. A 16-bit setting and a 2-bit mode code together give the division ratio.

In direct mode only the upper 12 bits of the setting count, and the ratio is that 12-bit number. In the three pulse-swallow modes, a 16/17 dual-modulus prescaler model runs under two counters. A 4-bit swallow counter is loaded from the low nibble of the setting, and a 12-bit main counter is loaded from the upper bits. The prescaler divides by 17 until the swallow count runs out, and then by 16 until the main count expires. The total ratio is therefore the full 16-bit setting. Two of the swallow modes place a fixed divide-by-4 or divide-by-8 stage in front.

A setting or mode that changes mid-cycle takes effect only at the next terminal count. Settings below the legal minimum are raised to that minimum.

Top module: `pswd_divider`

## Requirements
- R1: While reset is asserted, and for at least the first full divide period after reset is released, `div_pulse` stays low.
- R2: With mode code 2'b00 (direct), the period between pulses is `div_setting[15:4]` input cycles, and bits 3:0 have no effect on it.
- R3: In direct mode, a value of `div_setting[15:4]` below 16 is treated as 16.
- R4: With mode code 2'b01 (pulse swallow), the period is the full 16-bit `div_setting` value. Bits 3:0 set the number of divide-by-17 prescaler cycles, and bits 15:4 set the total number of prescaler cycles.
- R5: In any pulse-swallow mode (codes 01, 10 and 11), a setting below 528 is treated as 528.
- R6: Mode code 2'b10 gives a period of 4 times the pulse-swallow ratio.
- R7: Mode code 2'b11 gives a period of 8 times the pulse-swallow ratio.
- R8: Each output pulse lasts exactly one clock cycle.
- R9: A change to the setting or mode takes effect at the next terminal count. The divide cycle already in progress completes with the old ratio and is never cut short.
- R10: The largest setting, 0xFFFF in mode 2'b01, gives a period of 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divided input clock (VCO-derived) |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_setting | input | 16 | Division setting n |
| div_mode | input | 2 | 00 direct, 01 swallow, 10 swallow with /4 front, 11 swallow with /8 front |
| div_pulse | output | 1 | One-cycle pulse per completed divide cycle |

## Verification
The hardest case to reach is a setting or mode change that arrives partway through a divide cycle. The cycle in progress must keep its old ratio, and the new value must apply to the very next cycle with no truncated period in between. To get there, the bench locks onto an output pulse and changes the inputs in that same cycle, just after the terminal count has already loaded the counters. It then measures two intervals in a row. The first must equal the old ratio and the second the new one. Stepping through settings and modes in a chain this way covers every transition between direct mode, the swallow modes and the front-divided modes, as well as the clamped boundaries.

// File: rtl/pswd_pkg.sv
package pswd_pkg;
   typedef enum logic [1:0] {
      DIV_DIRECT  = 2'b00,
      DIV_SWALLOW = 2'b01,
      DIV_QUAD    = 2'b10,
      DIV_OCT     = 2'b11
   } div_mode_e;
endpackage

// File: rtl/pswd_setting_decode.sv
module pswd_setting_decode #(
   parameter int SET_W     = 16,
   parameter int SWALLOW_W = 4,
   parameter int PS_MIN    = 528,
   parameter int DIR_MIN   = 16,
   localparam int MAIN_W   = SET_W - SWALLOW_W
) (
   input  logic [SET_W-1:0]     setting,
   input  logic                 is_direct,
   output logic [MAIN_W-1:0]    main_load,
   output logic [SWALLOW_W-1:0] swallow_load
);
   logic [MAIN_W-1:0] dir_val;
   logic [SET_W-1:0]  ps_val;

   always_comb begin
      dir_val = setting[SET_W-1:SWALLOW_W];
      if (dir_val < MAIN_W'(DIR_MIN)) dir_val = MAIN_W'(DIR_MIN);
      ps_val = setting;
      if (ps_val < SET_W'(PS_MIN)) ps_val = SET_W'(PS_MIN);
      if (is_direct) begin
         main_load    = dir_val;
         swallow_load = '0;
      end else begin
         main_load    = ps_val[SET_W-1:SWALLOW_W];
         swallow_load = ps_val[SWALLOW_W-1:0];
      end
   end
endmodule

// File: rtl/pswd_front_div.sv
module pswd_front_div
   import pswd_pkg::*;
#(
   parameter int FRONT_A = 4,
   parameter int FRONT_B = 8,
   localparam int FW     = (FRONT_B > 1) ? $clog2(FRONT_B) : 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      restart,
   input  div_mode_e sel,
   output logic      tick
);
   logic [FW-1:0] cnt_q;
   logic [FW-1:0] last;

   generate
      if (FRONT_A < 1 || FRONT_B < FRONT_A) begin : g_bad_front
         $error("front divider ratios must satisfy 1 <= FRONT_A <= FRONT_B");
      end
   endgenerate

   always_comb begin
      unique case (sel)
         DIV_QUAD: last = FW'(FRONT_A - 1);
         DIV_OCT:  last = FW'(FRONT_B - 1);
         default:  last = '0;
      endcase
   end

   assign tick = (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (restart)    cnt_q <= '0;
      else if (tick)       cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/pswd_counter_core.sv
module pswd_counter_core #(
   parameter int SET_W     = 16,
   parameter int SWALLOW_W = 4,
   localparam int MAIN_W   = SET_W - SWALLOW_W,
   localparam int PC_W     = SWALLOW_W + 1,
   localparam int PRE_LO   = 1 << SWALLOW_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 swallow_mode,
   input  logic                 load,
   input  logic [MAIN_W-1:0]    main_load,
   input  logic [SWALLOW_W-1:0] swallow_load,
   output logic                 term,
   output logic [MAIN_W-1:0]    main_cnt,
   output logic [PC_W-1:0]      pre_cnt
);
   logic [PC_W-1:0]      pc_q;
   logic [SWALLOW_W-1:0] sw_q;
   logic [MAIN_W-1:0]    mc_q;
   logic [PC_W-1:0]      pc_last;
   logic                 pre_out;
   logic                 step;

   always_comb begin
      pc_last = (sw_q != '0) ? PC_W'(PRE_LO) : PC_W'(PRE_LO - 1);
      pre_out = tick && (pc_q == pc_last);
      step    = swallow_mode ? pre_out : tick;
      term    = step && (mc_q == MAIN_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
         sw_q <= '0;
         mc_q <= MAIN_W'(1);
      end else if (load || term) begin
         pc_q <= '0;
         sw_q <= swallow_load;
         mc_q <= main_load;
      end else begin
         if (swallow_mode && tick) pc_q <= pre_out ? '0 : pc_q + 1'b1;
         if (step) begin
            mc_q <= mc_q - 1'b1;
            if (swallow_mode && sw_q != '0) sw_q <= sw_q - 1'b1;
         end
      end
   end

   assign main_cnt = mc_q;
   assign pre_cnt  = pc_q;
endmodule

// File: rtl/pswd_divider.sv
module pswd_divider
   import pswd_pkg::*;
#(
   parameter int SET_W     = 16,
   parameter int SWALLOW_W = 4,
   parameter int PS_MIN    = 528,
   parameter int DIR_MIN   = 16,
   parameter int FRONT_A   = 4,
   parameter int FRONT_B   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] div_setting,
   input  logic [1:0]       div_mode,
   output logic             div_pulse
);
   localparam int MAIN_W = SET_W - SWALLOW_W;
   localparam int PC_W   = SWALLOW_W + 1;

   generate
      if (SWALLOW_W < 1 || MAIN_W < 2) begin : g_bad_width
         $error("setting must split into swallow and main fields");
      end
      if ((PS_MIN >> SWALLOW_W) < (1 << SWALLOW_W)) begin : g_bad_min
         $error("PS_MIN too small: main count must cover the swallow count");
      end
   endgenerate

   div_mode_e                mode_q;
   logic                     start_q;
   logic                     pulse_q;
   logic                     reload;
   logic                     term;
   logic                     tick;
   logic [MAIN_W-1:0]        main_load;
   logic [SWALLOW_W-1:0]     swallow_load;
   logic [MAIN_W-1:0]        main_cnt;
   logic [PC_W-1:0]          pre_cnt;
   div_mode_e                mode_in;

   assign mode_in = div_mode_e'(div_mode);
   assign reload  = start_q | term;

   pswd_setting_decode #(
      .SET_W(SET_W), .SWALLOW_W(SWALLOW_W), .PS_MIN(PS_MIN), .DIR_MIN(DIR_MIN)
   ) u_decode (
      .setting      (div_setting),
      .is_direct    (mode_in == DIV_DIRECT),
      .main_load    (main_load),
      .swallow_load (swallow_load)
   );

   pswd_front_div #(.FRONT_A(FRONT_A), .FRONT_B(FRONT_B)) u_front (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (reload),
      .sel     (mode_q),
      .tick    (tick)
   );

   pswd_counter_core #(.SET_W(SET_W), .SWALLOW_W(SWALLOW_W)) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .swallow_mode (mode_q != DIV_DIRECT),
      .load         (start_q),
      .main_load    (main_load),
      .swallow_load (swallow_load),
      .term         (term),
      .main_cnt     (main_cnt),
      .pre_cnt      (pre_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b1;
         mode_q  <= DIV_DIRECT;
         pulse_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         pulse_q <= term && !start_q;
         if (reload) mode_q <= mode_in;
      end
   end

   assign div_pulse = pulse_q;
endmodule

// File: rtl/pswd_divider_chk.sv
module pswd_divider_chk
   import pswd_pkg::*;
#(
   parameter int SWALLOW_W = 4,
   parameter int MAIN_W    = 12,
   parameter int PS_MIN    = 528,
   parameter int DIR_MIN   = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 div_pulse,
   input logic                 reload,
   input div_mode_e            mode_q,
   input logic [MAIN_W-1:0]    main_cnt,
   input logic [SWALLOW_W:0]   pre_cnt
);
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse); // R8
   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reload |=> $stable(mode_q)); // R9
   AST_DIRECT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (mode_q != DIV_DIRECT || main_cnt >= MAIN_W'(DIR_MIN))); // R3
   AST_SWALLOW_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (mode_q == DIV_DIRECT || main_cnt >= MAIN_W'(PS_MIN >> SWALLOW_W))); // R5
   AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cnt <= (SWALLOW_W+1)'(1 << SWALLOW_W)); // R4
   AST_MAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      main_cnt != '0); // R4
endmodule

bind pswd_divider pswd_divider_chk #(
   .SWALLOW_W(SWALLOW_W), .MAIN_W(MAIN_W), .PS_MIN(PS_MIN), .DIR_MIN(DIR_MIN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .div_pulse (div_pulse),
   .reload    (reload),
   .mode_q    (mode_q),
   .main_cnt  (main_cnt),
   .pre_cnt   (pre_cnt)
);

// File: tb/tb_pswd_divider.sv
module tb_pswd_divider;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] div_setting = 16'h0400;
   logic [1:0]  div_mode = 2'b00;
   logic        div_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit timed_out = 1'b0;

   always #5 clk = ~clk;

   pswd_divider dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .div_setting (div_setting),
      .div_mode    (div_mode),
      .div_pulse   (div_pulse)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) timed_out = 1'b1;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // ends at a negedge with div_pulse high; returns cycles since the last pulse
   task automatic next_pulse(output int c);
      c = 0;
      do begin
         @(negedge clk);
         c++;
      end while (!div_pulse && !timed_out);
   endtask

   // change inputs on a pulse, then check the old interval and the new one
   task automatic run_case(input logic [15:0] s, input logic [1:0] m,
                           input int old_exp, input int new_exp, input string tag);
      int p;
      next_pulse(p);
      div_setting = s;
      div_mode    = m;
      next_pulse(p);
      check(p == old_exp, {tag, " R9 old period kept"}, p, old_exp);
      next_pulse(p);
      check(p == new_exp, tag, p, new_exp);
      @(negedge clk);
      check(div_pulse == 1'b0, "R8 one-cycle pulse", int'(div_pulse), 0);
   endtask

   task automatic test_reset;
      int seen = 0;
      repeat (3) @(negedge clk);
      check(div_pulse == 1'b0, "R1 low in reset", int'(div_pulse), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (div_pulse) seen++;
      end
      check(seen == 0, "R1 no early pulse", seen, 0);
   endtask

   initial begin
      test_reset();
      run_case(16'h0405, 2'b00, 64,   64,    "R2 low bits ignored");
      run_case(16'h0000, 2'b00, 64,   16,    "R3 direct clamp zero");
      run_case(16'h00F7, 2'b00, 16,   16,    "R3 direct clamp 15");
      run_case(16'hFFF0, 2'b00, 16,   4095,  "R2 direct max");
      run_case(16'h0215, 2'b01, 4095, 533,   "R4 swallow 533");
      run_case(16'h0100, 2'b01, 533,  528,   "R5 swallow clamp");
      run_case(16'h0210, 2'b01, 528,  528,   "R5 swallow at minimum");
      run_case(16'h0300, 2'b10, 528,  3072,  "R6 quad front");
      run_case(16'h0213, 2'b11, 3072, 4248,  "R7 oct front");
      run_case(16'h0050, 2'b10, 4248, 2112,  "R5 clamp with quad front");
      run_case(16'h1234, 2'b01, 2112, 4660,  "R4 swallow 4660");
      run_case(16'h0200, 2'b00, 4660, 32,    "R2 back to direct");
      run_case(16'hFFFF, 2'b01, 32,   65535, "R10 swallow max");
      if (timed_out) check(1'b0, "watchdog expired", cycles, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule